// File: doc/BRIEF.md
# SPI Peripheral Word Port with Command/Data Start Bit

This block is the target side of a four-wire serial link. It handles one word per chip-select frame. While the chip select is low, it shifts a word in from the controller and shifts a stored word out. The serial clock idles low. The block samples the serial clock, the chip select and the incoming data line with its own functional clock, using short synchronizer chains, and finds edges in that domain. The serial pins never clock any flop directly.

Two settings change the timing. The phase input selects which serial-clock edge samples and which edge changes the output. The start-bit enable adds one slot ahead of the word. The bit received in that slot becomes a flag: 1 marks the word as data and 0 marks it as a command. On the output line, that slot carries a 0.

Loading of the outgoing word is possible only between frames. If no new word is loaded, the block sends the same word again in the next frame. A received word is reported with a one-cycle strobe and a command/data flag. A frame that ends early reports nothing.

Top module: `spi_tgt_port`

## Requirements
- R1: `miso_oe` is 0 whenever `cs_n` has been high for `SYNC_STAGES`+2 functional cycles, and it is 1 while a frame is in progress. `miso` is 0 whenever `miso_oe` is 0.
- R2: The outgoing word leaves most-significant bit first. Each following slot carries the next lower bit.
- R3: With `cfg_phase`=0, the first output bit is on `miso` before the first rising serial-clock edge. `mosi` is sampled on rising edges (odd edges). `miso` changes after falling edges (even edges).
- R4: With `cfg_phase`=1, `miso` advances after each rising edge except the first, which presents the first bit. `mosi` is sampled on falling edges (even edges).
- R5: With `cfg_start_en`=1, a frame has `WORD_W`+1 slots. The first received bit is reported on `rx_is_data` (1 = data, 0 = command), and the next `WORD_W` bits form `rx_word`. `miso` carries 0 in the first slot, then the word.
- R6: With `cfg_start_en`=0, a frame has `WORD_W` slots and `rx_is_data` is reported as 1.
- R7: `rx_valid` is a single-cycle pulse raised after the last bit of a frame is sampled. `rx_word` and `rx_is_data` change only with that pulse and hold their values until the next one.
- R8: If `cs_n` rises before all slots are sampled, the partial word is dropped. No `rx_valid` is raised, and the next frame starts from its first slot. `rx_valid` never appears later than `SYNC_STAGES`+2 cycles after `cs_n` rises.
- R9: Serial-clock edges after the last slot, within the same frame, produce no further `rx_valid`.
- R10: `tx_load` captures `tx_word` only while `cs_n` is high. A load pulse during a frame has no effect on this frame or the next.
- R11: When no load happens between frames, the previous outgoing word is sent again.
- R12: After reset, `rx_valid` and `miso_oe` are 0, and the stored outgoing word is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_phase | input | 1 | Clock phase select; stable while cs_n is low |
| cfg_start_en | input | 1 | Enables the leading command/data slot; stable while cs_n is low |
| tx_word | input | WORD_W | Word to send in later frames |
| tx_load | input | 1 | Capture strobe for tx_word, honoured only between frames |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| sclk | input | 1 | Serial clock, idle low, asynchronous |
| mosi | input | 1 | Serial data from the controller |
| miso | output | 1 | Serial data to the controller |
| miso_oe | output | 1 | Output enable for the miso pad |
| rx_word | output | WORD_W | Last complete received word |
| rx_is_data | output | 1 | Flag of the last word: 1 data, 0 command |
| rx_valid | output | 1 | One-cycle strobe for a new rx_word |

## Verification
The bound checker watches properties that hold on every cycle:
- the output line is released after chip select has been high for a while, and stays quiet while released;
- the valid strobe lasts exactly one cycle and never appears long after the frame ends;
- the received outputs stay steady between strobes;
- the flag reads as data when the start slot is off.

Only the directed scenarios can show the rest:
- bit order and slot placement on both lines under both phases;
- the decoded command/data value;
- the dropping of cut-short frames and the ignoring of surplus clocks;
- the gating and repetition of the outgoing word.

// File: rtl/spi_tgt_pkg.sv
// Shared types for the SPI target word port.
// Assumes: the event bundle is produced once per functional cycle by the
// edge decoder and consumed by the transmit and receive paths.
package spi_tgt_pkg;

    // Per-cycle serial events, all in the functional clock domain.
    typedef struct packed {
        logic active;   // chip select currently asserted (synchronized)
        logic start;    // chip select has just asserted
        logic stop;     // chip select has just released
        logic sample;   // capture the incoming data bit this cycle
        logic shift;    // advance the outgoing data bit this cycle
    } spi_tgt_evt_t;

    // Width of a counter that can hold 0 .. n inclusive.
    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/spi_tgt_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous single-bit inputs.
// Assumes: each bit is independent; STAGES >= 2; RST_VAL gives the
// idle level that each bit shows out of reset.
module spi_tgt_sync #(
    parameter int unsigned         N       = 3,
    parameter int unsigned         STAGES  = 2,
    parameter logic [N-1:0]        RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    logic [N-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage samples the raw asynchronous inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= din;
            end
        end else begin : g_next
            // Later stages resolve metastability of the stage before.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/spi_tgt_edge.sv
// Converts the synchronized serial clock and chip select into per-cycle
// events, choosing the sample and shift edges from the phase setting.
// Assumes: idle-low serial clock; cfg_phase is stable during a frame.
module spi_tgt_edge
    import spi_tgt_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk_s,
    input  logic         csn_s,
    input  logic         cfg_phase,
    output spi_tgt_evt_t evt
);

    logic sclk_q;
    logic csn_q;
    logic first_seen;
    logic rise;
    logic fall;

    // Hold the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            csn_q  <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            csn_q  <= csn_s;
        end
    end

    // Remember whether the first rising edge of the frame has passed.
    always_ff @(posedge clk) begin
        if (!rst_n)                      first_seen <= 1'b0;
        else if (csn_q && !csn_s)        first_seen <= 1'b0;
        else if (!csn_s && rise)         first_seen <= 1'b1;
    end

    // Decode edges and map them onto sample/shift per phase.
    always_comb begin
        rise       = sclk_s && !sclk_q;
        fall       = !sclk_s && sclk_q;
        evt.active = !csn_s;
        evt.start  = csn_q && !csn_s;
        evt.stop   = !csn_q && csn_s;
        if (cfg_phase) begin
            evt.sample = !csn_s && fall;
            evt.shift  = !csn_s && rise && first_seen;
        end else begin
            evt.sample = !csn_s && rise;
            evt.shift  = !csn_s && fall;
        end
    end

endmodule

// File: rtl/spi_tgt_tx.sv
// Transmit path: holds the outgoing word, loads it into a shifter at the
// start of each frame and drives the output line while selected.
// Assumes: loads are honoured only between frames; cfg_start_en stable
// during a frame.
module spi_tgt_tx
    import spi_tgt_pkg::*;
#(
    parameter int unsigned WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  spi_tgt_evt_t      evt,
    input  logic              cfg_start_en,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_load,
    output logic              miso,
    output logic              miso_oe
);

    localparam int unsigned SR_W = WORD_W + 1;

    logic [WORD_W-1:0] hold_q;
    logic [SR_W-1:0]   sr_q;
    logic              oe_q;

    // Capture a new outgoing word only while no frame is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n)                       hold_q <= '0;
        else if (tx_load && !evt.active)  hold_q <= tx_word;
    end

    // Load the shifter at frame start (0 in the start slot) and advance it.
    always_ff @(posedge clk) begin
        if (!rst_n)          sr_q <= '0;
        else if (evt.start)  sr_q <= cfg_start_en ? {1'b0, hold_q} : {hold_q, 1'b0};
        else if (evt.shift)  sr_q <= {sr_q[SR_W-2:0], 1'b0};
    end

    // Enable the pad in step with the shifter contents.
    always_ff @(posedge clk) begin
        if (!rst_n) oe_q <= 1'b0;
        else        oe_q <= evt.active;
    end

    assign miso_oe = oe_q;
    assign miso    = oe_q && sr_q[SR_W-1];

endmodule

// File: rtl/spi_tgt_rx.sv
// Receive path: counts sampled slots, splits off the optional start slot,
// assembles the word and reports it once per frame.
// Assumes: a partial frame is simply forgotten at the next frame start.
module spi_tgt_rx
    import spi_tgt_pkg::*;
#(
    parameter int unsigned WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  spi_tgt_evt_t      evt,
    input  logic              cfg_start_en,
    input  logic              mosi_s,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_is_data,
    output logic              rx_valid
);

    localparam int unsigned CW = cnt_bits(WORD_W + 1);

    logic [CW-1:0]     cnt_q;
    logic              done_q;
    logic              flag_q;
    logic [WORD_W-1:0] sr_q;
    logic              last;
    logic              is_flag_slot;
    logic [WORD_W-1:0] next_word;

    // Classify the current slot.
    always_comb begin
        last         = (cnt_q == (CW'(WORD_W - 1) + CW'(cfg_start_en)));
        is_flag_slot = cfg_start_en && (cnt_q == '0);
        next_word    = {sr_q[WORD_W-2:0], mosi_s};
    end

    // Slot counter and one-word-per-frame latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (evt.start) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (evt.sample && !done_q) begin
            cnt_q  <= cnt_q + 1'b1;
            done_q <= last;
        end
    end

    // Capture the command/data slot or shift a data bit in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b1;
            sr_q   <= '0;
        end else if (evt.sample && !done_q) begin
            if (is_flag_slot) flag_q <= mosi_s;
            else              sr_q   <= next_word;
        end
    end

    // Publish the completed word with a single-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid   <= 1'b0;
            rx_word    <= '0;
            rx_is_data <= 1'b1;
        end else begin
            rx_valid <= 1'b0;
            if (evt.sample && !done_q && last) begin
                rx_valid   <= 1'b1;
                rx_word    <= next_word;
                rx_is_data <= cfg_start_en ? flag_q : 1'b1;
            end
        end
    end

endmodule

// File: rtl/spi_tgt_port.sv
// SPI target word port: synchronizes the serial pins, decodes edges, and
// runs the transmit and receive paths for one word per frame.
// Assumes: serial clock half-period >= 4 functional cycles; first edge at
// least half a serial period after chip select falls; idle-low clock.
module spi_tgt_port
    import spi_tgt_pkg::*;
#(
    parameter int unsigned WORD_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_phase,
    input  logic              cfg_start_en,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_load,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_is_data,
    output logic              rx_valid
);

    localparam int unsigned PINS = 3;

    logic [PINS-1:0] pins_s;
    spi_tgt_evt_t    evt;

    spi_tgt_sync #(
        .N       (PINS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b010)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({mosi, cs_n, sclk}),
        .dout  (pins_s)
    );

    spi_tgt_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (pins_s[0]),
        .csn_s     (pins_s[1]),
        .cfg_phase (cfg_phase),
        .evt       (evt)
    );

    spi_tgt_tx #(.WORD_W(WORD_W)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt          (evt),
        .cfg_start_en (cfg_start_en),
        .tx_word      (tx_word),
        .tx_load      (tx_load),
        .miso         (miso),
        .miso_oe      (miso_oe)
    );

    spi_tgt_rx #(.WORD_W(WORD_W)) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt          (evt),
        .cfg_start_en (cfg_start_en),
        .mosi_s       (pins_s[2]),
        .rx_word      (rx_word),
        .rx_is_data   (rx_is_data),
        .rx_valid     (rx_valid)
    );

endmodule

// File: rtl/spi_tgt_port_chk.sv
// Property checker for spi_tgt_port, attached by bind below.
// Assumes: observes ports only; keeps its own count of idle cycles.
module spi_tgt_port_chk #(
    parameter int unsigned WORD_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              cfg_start_en,
    input logic              miso,
    input logic              miso_oe,
    input logic [WORD_W-1:0] rx_word,
    input logic              rx_is_data,
    input logic              rx_valid
);

    localparam int unsigned LAT = SYNC_STAGES + 2;

    logic [7:0] idle_cnt;

    // Count consecutive cycles with chip select high (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n)               idle_cnt <= '0;
        else if (cs_n == 1'b0)    idle_cnt <= '0;
        else if (idle_cnt != '1)  idle_cnt <= idle_cnt + 1'b1;
    end

    a_r1_oe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_cnt >= 8'(LAT)) |-> !miso_oe);

    a_r1_quiet_line: assert property (@(posedge clk) disable iff (!rst_n)
        !miso_oe |-> !miso);

    a_r6_data_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cfg_start_en) |-> rx_is_data);

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(rx_word) && $stable(rx_is_data)));

    a_r8_valid_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (idle_cnt <= 8'(LAT)));

endmodule

bind spi_tgt_port spi_tgt_port_chk #(
    .WORD_W      (WORD_W),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .cfg_start_en (cfg_start_en),
    .miso         (miso),
    .miso_oe      (miso_oe),
    .rx_word      (rx_word),
    .rx_is_data   (rx_is_data),
    .rx_valid     (rx_valid)
);

// File: tb/spi_tgt_port_bench.sv
`timescale 1ns/1ps
// Directed bench for spi_tgt_port: a modelled controller drives frames and
// each scenario task checks its own results.
module spi_tgt_port_bench;

    localparam int W = 8;
    localparam int H = 8;   // serial half-period in functional cycles

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_phase = 1'b0;
    logic         cfg_start_en = 1'b0;
    logic [W-1:0] tx_word = '0;
    logic         tx_load = 1'b0;
    logic         cs_n = 1'b1;
    logic         sclk = 1'b0;
    logic         mosi = 1'b0;
    logic         miso;
    logic         miso_oe;
    logic [W-1:0] rx_word;
    logic         rx_is_data;
    logic         rx_valid;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 0;
    int  v_count = 0;
    logic [W-1:0] v_word;
    logic         v_flag;
    logic [15:0]  got;
    logic         got_oe;

    always #2 clk = ~clk;

    spi_tgt_port #(.WORD_W(W), .SYNC_STAGES(2)) u_spi_tgt_port (
        .clk(clk), .rst_n(rst_n), .cfg_phase(cfg_phase),
        .cfg_start_en(cfg_start_en), .tx_word(tx_word), .tx_load(tx_load),
        .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso),
        .miso_oe(miso_oe), .rx_word(rx_word), .rx_is_data(rx_is_data),
        .rx_valid(rx_valid)
    );

    // Record every received-word strobe.
    always @(negedge clk) begin
        if (rx_valid) begin
            v_count = v_count + 1;
            v_word  = rx_word;
            v_flag  = rx_is_data;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic load(input logic [W-1:0] w);
        @(negedge clk);
        tx_word = w;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    // Word seen on miso starting at slot 'first', MSB first.
    function automatic logic [W-1:0] miso_word(input int first);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[W-1-i] = got[first+i];
        return r;
    endfunction

    // One frame as controller: nclk clock pulses, optional mid-frame load.
    task automatic xfer(input logic ph, input logic se, input logic sb,
                        input logic [W-1:0] mw, input int nclk,
                        input logic mid_load, input logic [W-1:0] mid_word);
        logic [W:0] bits;
        int nb;
        nb = se ? W + 1 : W;
        bits = se ? {sb, mw} : {1'b0, mw};
        cfg_phase = ph;
        cfg_start_en = se;
        got = '0;
        got_oe = 1'b0;
        @(negedge clk);
        cs_n = 1'b0;
        mosi = ph ? 1'b0 : bits[nb-1];
        tick(H);
        for (int i = 0; i < nclk; i++) begin
            logic b;
            logic bn;
            b  = (i < nb) ? bits[nb-1-i] : 1'b0;
            bn = (i + 1 < nb) ? bits[nb-2-i] : 1'b0;
            if (!ph) begin
                sclk = 1'b1;
                got[i] = miso;
                if (i == 0) got_oe = miso_oe;
                tick(H);
                sclk = 1'b0;
                mosi = bn;
                tick(H);
            end else begin
                sclk = 1'b1;
                mosi = b;
                tick(H);
                sclk = 1'b0;
                got[i] = miso;
                if (i == 0) got_oe = miso_oe;
                tick(H);
            end
            if (mid_load && i == 1) begin
                tx_word = mid_word;
                tx_load = 1'b1;
                tick(1);
                tx_load = 1'b0;
            end
        end
        cs_n = 1'b1;
        tick(4 * H);
    endtask

    task automatic t_reset;
        chk("R12", "rx_valid after reset", 32'(rx_valid), 32'h0);
        chk("R12", "miso_oe after reset", 32'(miso_oe), 32'h0);
        xfer(1'b0, 1'b0, 1'b0, 8'h5B, W, 1'b0, '0);
        chk("R12", "reset word on miso", 32'(miso_word(0)), 32'h00);
    endtask

    task automatic t_phase0;
        int base;
        load(8'hA5);
        base = v_count;
        xfer(1'b0, 1'b0, 1'b0, 8'h3C, W, 1'b0, '0);
        chk("R2", "phase0 miso MSB first", 32'(miso_word(0)), 32'hA5);
        chk("R1", "oe during frame", 32'(got_oe), 32'h1);
        chk("R1", "oe after frame", 32'(miso_oe), 32'h0);
        chk("R7", "one strobe", 32'(v_count - base), 32'h1);
        chk("R3", "phase0 rx word", 32'(v_word), 32'h3C);
        chk("R6", "flag without start slot", 32'(v_flag), 32'h1);
    endtask

    task automatic t_phase1;
        int base;
        load(8'h96);
        base = v_count;
        xfer(1'b1, 1'b0, 1'b0, 8'hC3, W, 1'b0, '0);
        chk("R4", "phase1 miso word", 32'(miso_word(0)), 32'h96);
        chk("R4", "phase1 strobes", 32'(v_count - base), 32'h1);
        chk("R4", "phase1 rx word", 32'(v_word), 32'hC3);
    endtask

    task automatic t_start;
        int base;
        load(8'h5A);
        base = v_count;
        xfer(1'b0, 1'b1, 1'b0, 8'h81, W + 1, 1'b0, '0);
        chk("R5", "start slot on miso", 32'(got[0]), 32'h0);
        chk("R5", "word after start slot", 32'(miso_word(1)), 32'h5A);
        chk("R5", "command word", 32'(v_word), 32'h81);
        chk("R5", "command flag", 32'(v_flag), 32'h0);
        xfer(1'b1, 1'b1, 1'b1, 8'h7E, W + 1, 1'b0, '0);
        chk("R5", "phase1 data word", 32'(v_word), 32'h7E);
        chk("R5", "data flag", 32'(v_flag), 32'h1);
        chk("R5", "strobes for two frames", 32'(v_count - base), 32'h2);
    endtask

    task automatic t_partial;
        int base;
        logic [W-1:0] prev;
        prev = rx_word;
        base = v_count;
        xfer(1'b0, 1'b0, 1'b0, 8'hF0, 5, 1'b0, '0);
        chk("R8", "no strobe on short frame", 32'(v_count - base), 32'h0);
        chk("R7", "rx_word held", 32'(rx_word), 32'(prev));
        xfer(1'b0, 1'b0, 1'b0, 8'h69, W, 1'b0, '0);
        chk("R8", "frame after short one", 32'(v_word), 32'h69);
        chk("R8", "strobe after short one", 32'(v_count - base), 32'h1);
    endtask

    task automatic t_extra;
        int base;
        base = v_count;
        xfer(1'b0, 1'b0, 1'b0, 8'hD2, W + 3, 1'b0, '0);
        chk("R9", "single strobe with surplus clocks", 32'(v_count - base), 32'h1);
        chk("R9", "word with surplus clocks", 32'(v_word), 32'hD2);
    endtask

    task automatic t_load_gate;
        load(8'h11);
        xfer(1'b0, 1'b0, 1'b0, 8'h00, W, 1'b1, 8'h22);
        chk("R10", "word in frame with mid load", 32'(miso_word(0)), 32'h11);
        xfer(1'b1, 1'b0, 1'b0, 8'h00, W, 1'b0, '0);
        chk("R10", "mid-frame load ignored", 32'(miso_word(0)), 32'h11);
        chk("R11", "word repeated", 32'(miso_word(0)), 32'h11);
        load(8'h22);
        xfer(1'b0, 1'b0, 1'b0, 8'h00, W, 1'b0, '0);
        chk("R10", "idle load taken", 32'(miso_word(0)), 32'h22);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(3);
        t_reset();
        t_phase0();
        t_phase1();
        t_start();
        t_partial();
        t_extra();
        t_load_gate();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule